// File: doc/BRIEF.md
# Free-Running Counter with Capture/Compare Channels

The block is a 16-bit up-counter with two channel registers behind a small byte-wide register bus. While it is enabled, the counter advances by one on every clock. Each channel either compares its stored value against the counter and pulses a match output, or captures the counter value on a rising edge of its trigger input. An option register holds one capture/compare selector per channel and an overflow flag. The flag is set when the counter wraps, and the same event produces a one-cycle interrupt pulse.

Two operating modes are modelled. In free-running mode each channel follows its selector bit. In pulse-width mode both channels capture, whatever their selectors say. The two remaining mode codes give a plain counting mode, in which both channels compare and no overflow is reported. Software clears the overflow flag by writing 0 to it and can never set it. Clearing the enable bit wipes the flag and both selectors. A selector change attempted while the counter runs is refused and recorded on a sticky debug output.

Top module: `fr_timer_cc`

## Requirements
- R1: After reset, every register reads 0x00, the counter reads 0, and `ovf_irq`, `cmp_match` and `dbg_sel_err` are low.
- R2: While enabled, the counter advances by exactly one per clock and wraps from 0xFFFF to 0x0000. While disabled, it reads 0.
- R3: In free-running mode (mode 00) or pulse-width mode (mode 01), a wrap sets option bit 0. It also drives `ovf_irq` high for the single cycle that follows the wrap edge.
- R4: In mode codes 10 and 11, a wrap neither sets option bit 0 nor raises `ovf_irq`.
- R5: A write of 0 to option bit 0 clears the flag, and a write of 1 leaves it unchanged. Reading the flag does not clear it. If a clearing write lands on the same edge as a wrap, the flag ends up set.
- R6: A control write that turns the enable bit (control bit 7) from 1 to 0 clears option bit 0 and both selector bits at that edge.
- R7: While enabled, a selector write whose value differs from the current one is ignored and sets `dbg_sel_err`, which stays set until reset. A write of the same value is accepted silently. While disabled, selector writes take effect.
- R8: A capturing channel loads the counter value present during the cycle in which its trigger is first seen high. Holding the trigger high does not capture again.
- R9: A comparing channel drives its `cmp_match` bit high for one cycle, starting in the cycle after the one in which the counter equals the channel value.
- R10: Option bits 4 (channel 0) and 5 (channel 1) select capture when 1 and compare when 0, and this applies only in mode 00. In mode 01 both channels capture. In modes 10 and 11 both channels compare, and triggers are ignored.
- R11: Option bits 1, 2, 3, 6 and 7 always read 0.
- R12: Register map. Address 0 is control: bit 7 is enable, bits 1:0 are the mode. Address 1 is the option register. Addresses 2/3 hold channel 0 low/high, 4/5 hold channel 1 low/high, and 6/7 give the counter low/high (read only). A write changes only the bits set in `bus_wmask`, and reads are combinational from `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_wmask | input | 8 | Per-bit write enable (0xFF for a byte write) |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cap_trig | input | 2 | Capture triggers, one per channel |
| cmp_match | output | 2 | Compare match pulses, one per channel |
| ovf_irq | output | 1 | Overflow interrupt pulse |
| dbg_sel_err | output | 1 | Sticky refused-selector-write indicator |

## Verification
Register writes take effect at the clock edge that ends the write cycle. The bench therefore samples read data at the next falling edge, and compare matches and overflow pulses one cycle after the counter value that causes them. The bench keeps its own cycle count from the enabling edge and derives the expected counter value from it. Each trigger, clearing write and compare check is placed on the exact counter value where a result is due. The clearing write for the simultaneous-overflow case is driven in the cycle where the counter shows 0xFFFF.

// File: rtl/fr_tmr_pkg.sv
package fr_tmr_pkg;

   typedef enum logic [1:0] {
      MODE_FREE    = 2'b00,
      MODE_PULSE   = 2'b01,
      MODE_PLAIN_A = 2'b10,
      MODE_PLAIN_B = 2'b11
   } tmr_mode_e;

   localparam int unsigned ADR_CTL     = 0;
   localparam int unsigned ADR_OPT     = 1;
   localparam int unsigned ADR_CH_BASE = 2;

   localparam int unsigned CTL_EN_BIT   = 7;
   localparam int unsigned OPT_FLAG_BIT = 0;
   localparam int unsigned OPT_SEL_LSB  = 4;

   function automatic logic [7:0] bit_merge(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] mask);
      return (old_v & ~mask) | (new_v & mask);
   endfunction

endpackage

// File: rtl/fr_tmr_counter.sv
module fr_tmr_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ovf_mode,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf_evt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (!en) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   assign ovf_evt = en && ovf_mode && (cnt == CNT_MAX);
endmodule

// File: rtl/fr_tmr_regs.sv
module fr_tmr_regs
   import fr_tmr_pkg::*;
#(
   parameter int unsigned NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_ctl,
   input  logic           wr_opt,
   input  logic [7:0]     wdata,
   input  logic [7:0]     wmask,
   input  logic           ovf_evt,
   output logic           en,
   output tmr_mode_e      mode,
   output logic [NCH-1:0] sel,
   output logic           ovf,
   output logic           sel_err,
   output logic [7:0]     ctl_rd,
   output logic [7:0]     opt_rd
);
   logic [7:0]     ctl_nx;
   logic [7:0]     opt_nx;
   logic [NCH-1:0] sel_req;
   logic           dis_evt;

   always_comb begin
      ctl_rd = '0;
      ctl_rd[CTL_EN_BIT] = en;
      ctl_rd[1:0] = mode;
      opt_rd = '0;
      opt_rd[OPT_FLAG_BIT] = ovf;
      opt_rd[OPT_SEL_LSB +: NCH] = sel;
   end

   assign ctl_nx  = bit_merge(ctl_rd, wdata, wmask);
   assign opt_nx  = bit_merge(opt_rd, wdata, wmask);
   assign sel_req = opt_nx[OPT_SEL_LSB +: NCH];
   assign dis_evt = wr_ctl && en && !ctl_nx[CTL_EN_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= 1'b0;
         mode <= MODE_FREE;
      end else if (wr_ctl) begin
         en   <= ctl_nx[CTL_EN_BIT];
         mode <= tmr_mode_e'(ctl_nx[1:0]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel     <= '0;
         sel_err <= 1'b0;
      end else if (dis_evt) begin
         sel <= '0;
      end else if (wr_opt) begin
         if (!en)                 sel     <= sel_req;
         else if (sel_req != sel) sel_err <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        ovf <= 1'b0;
      else if (dis_evt)  ovf <= 1'b0;
      else if (ovf_evt)  ovf <= 1'b1;
      else if (wr_opt && wmask[OPT_FLAG_BIT] && !wdata[OPT_FLAG_BIT])
                         ovf <= 1'b0;
   end
endmodule

// File: rtl/fr_tmr_channel.sv
module fr_tmr_channel
   import fr_tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             is_cap,
   input  logic             trig,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wdata,
   input  logic [7:0]       wmask,
   output logic [CNT_W-1:0] val,
   output logic             match
);
   logic trig_q;
   logic rise;

   assign rise = trig && !trig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= trig;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val <= '0;
      end else if (en && is_cap && rise) begin
         val <= cnt;
      end else begin
         if (wr_lo) val[7:0]  <= bit_merge(val[7:0], wdata, wmask);
         if (wr_hi) val[15:8] <= bit_merge(val[15:8], wdata, wmask);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) match <= 1'b0;
      else        match <= en && !is_cap && (cnt == val);
   end
endmodule

// File: rtl/fr_timer_cc.sv
module fr_timer_cc
   import fr_tmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NCH    = 2,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   input  logic [7:0]        bus_wmask,
   output logic [7:0]        bus_rdata,
   input  logic [NCH-1:0]    cap_trig,
   output logic [NCH-1:0]    cmp_match,
   output logic              ovf_irq,
   output logic              dbg_sel_err
);
   localparam int unsigned ADR_CNT = ADR_CH_BASE + 2 * NCH;
   localparam int unsigned N_ADR   = ADR_CNT + 2;

   if (CNT_W != 16) begin : g_bad_width
      $error("fr_timer_cc: CNT_W must be 16 for the byte register layout");
   end
   if (NCH < 1 || NCH > 2) begin : g_bad_nch
      $error("fr_timer_cc: NCH must be 1 or 2");
   end
   if ((1 << ADDR_W) < N_ADR) begin : g_bad_addr
      $error("fr_timer_cc: ADDR_W too small for the register map");
   end

   logic                      en;
   tmr_mode_e                 mode;
   logic [NCH-1:0]            sel;
   logic                      ovf;
   logic                      sel_err;
   logic [7:0]                ctl_rd;
   logic [7:0]                opt_rd;
   logic [CNT_W-1:0]          cnt;
   logic                      ovf_evt;
   logic                      ovf_mode;
   logic [NCH-1:0]            is_cap;
   logic [NCH-1:0][CNT_W-1:0] ch_val;

   assign ovf_mode    = (mode == MODE_FREE) || (mode == MODE_PULSE);
   assign dbg_sel_err = sel_err;

   fr_tmr_regs #(.NCH(NCH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctl  (bus_wr && (bus_addr == ADDR_W'(ADR_CTL))),
      .wr_opt  (bus_wr && (bus_addr == ADDR_W'(ADR_OPT))),
      .wdata   (bus_wdata),
      .wmask   (bus_wmask),
      .ovf_evt (ovf_evt),
      .en      (en),
      .mode    (mode),
      .sel     (sel),
      .ovf     (ovf),
      .sel_err (sel_err),
      .ctl_rd  (ctl_rd),
      .opt_rd  (opt_rd)
   );

   fr_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .ovf_mode (ovf_mode),
      .cnt      (cnt),
      .ovf_evt  (ovf_evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ovf_irq <= 1'b0;
      else        ovf_irq <= ovf_evt;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign is_cap[i] = (mode == MODE_FREE) ? sel[i] : (mode == MODE_PULSE);

      fr_tmr_channel #(.CNT_W(CNT_W)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (en),
         .is_cap (is_cap[i]),
         .trig   (cap_trig[i]),
         .cnt    (cnt),
         .wr_lo  (bus_wr && (bus_addr == ADDR_W'(ADR_CH_BASE + 2 * i))),
         .wr_hi  (bus_wr && (bus_addr == ADDR_W'(ADR_CH_BASE + 2 * i + 1))),
         .wdata  (bus_wdata),
         .wmask  (bus_wmask),
         .val    (ch_val[i]),
         .match  (cmp_match[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_CTL)) bus_rdata = ctl_rd;
      if (bus_addr == ADDR_W'(ADR_OPT)) bus_rdata = opt_rd;
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == ADDR_W'(ADR_CH_BASE + 2 * i))     bus_rdata = ch_val[i][7:0];
         if (bus_addr == ADDR_W'(ADR_CH_BASE + 2 * i + 1)) bus_rdata = ch_val[i][15:8];
      end
      if (bus_addr == ADDR_W'(ADR_CNT))     bus_rdata = cnt[7:0];
      if (bus_addr == ADDR_W'(ADR_CNT + 1)) bus_rdata = cnt[15:8];
   end
endmodule

// File: rtl/fr_timer_cc_chk.sv
module fr_timer_cc_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NCH    = 2,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [1:0]        mode,
   input logic [CNT_W-1:0]  cnt,
   input logic [NCH-1:0]    sel,
   input logic              ovf,
   input logic              sel_err,
   input logic              ovf_irq,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_rdata
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   // R2: one step per enabled clock, zero after a disabled one
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en) |-> cnt == CNT_W'($past(cnt) + 1'b1));
   a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> cnt == '0);

   // R3: wrap in an overflow-reporting mode yields the pulse
   a_r3_wrap_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt == CMAX && !mode[1]) |=> ovf_irq);

   // R4: no pulse unless a wrap happened in mode 00/01
   a_r4_no_irq_other: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> $past(en && cnt == CMAX && !mode[1]));

   // R5: the flag only rises from hardware
   a_r5_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(en && cnt == CMAX && !mode[1]));

   // R6: disabling wipes flag and selectors
   a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |-> (!ovf && sel == '0));

   // R7: selectors frozen while running, error only from a running write
   a_r7_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> $stable(sel));
   a_r7_err_when_running: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_err) |-> $past(en));

   // R11: reserved option bits read as zero
   a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(1)) |-> (bus_rdata & 8'hCE) == 8'h00);
endmodule

bind fr_timer_cc fr_timer_cc_chk #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .mode      (mode),
   .cnt       (cnt),
   .sel       (sel),
   .ovf       (ovf),
   .sel_err   (sel_err),
   .ovf_irq   (ovf_irq),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata)
);

// File: tb/fr_timer_cc_test.sv
module fr_timer_cc_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] wmask = '0;
   logic [7:0] rdata;
   logic [1:0] trig = '0;
   logic [1:0] match;
   logic       irq;
   logic       sel_err;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int t_en = 0;
   int irq_seen = 0;
   bit finished = 1'b0;

   fr_timer_cc uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
      .bus_wdata(wdata), .bus_wmask(wmask), .bus_rdata(rdata),
      .cap_trig(trig), .cmp_match(match), .ovf_irq(irq),
      .dbg_sel_err(sel_err)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (irq) irq_seen <= irq_seen + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic [7:0] m);
      @(negedge clk);
      addr = a; wdata = d; wmask = m; wr = 1'b1;
      @(posedge clk);
      #1;
      wr = 1'b0; wmask = '0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      peek(a, d);
   endtask

   task automatic wait_cnt(input logic [15:0] v);
      do @(negedge clk); while (16'(cyc - t_en) != v);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      bus_read(3'd0, d); chk("R1 ctl", d, 0);
      bus_read(3'd1, d); chk("R1 opt", d, 0);
      bus_read(3'd6, d); chk("R1 cnt lo", d, 0);
      bus_read(3'd7, d); chk("R1 cnt hi", d, 0);
      chk("R1 irq", irq, 0);
      chk("R1 match", match, 0);
      chk("R1 sel_err", sel_err, 0);
   endtask

   task automatic t_option_fields;
      logic [7:0] d;
      bus_write(3'd1, 8'hFF, 8'hFF);
      bus_read(3'd1, d); chk("R11 R5 opt after 0xFF", d, 8'h30);
      bus_write(3'd1, 8'h00, 8'h10);
      bus_read(3'd1, d); chk("R12 bit write opt", d, 8'h20);
      chk("R7 no error while disabled", sel_err, 0);
   endtask

   task automatic t_pulse_mode;
      logic [7:0] d;
      bus_write(3'd2, 8'h34, 8'hFF);
      bus_write(3'd3, 8'h12, 8'hFF);
      bus_read(3'd2, d); chk("R12 ch0 lo", d, 8'h34);
      bus_read(3'd3, d); chk("R12 ch0 hi", d, 8'h12);
      bus_write(3'd0, 8'h81, 8'hFF);
      t_en = cyc;
      wait_cnt(16'd9);
      trig[0] = 1'b1;
      @(negedge clk); trig[0] = 1'b0;
      bus_read(3'd2, d); chk("R10 R8 pulse mode capture lo", d, 9);
      bus_read(3'd3, d); chk("R10 R8 pulse mode capture hi", d, 0);
      bus_write(3'd1, 8'h30, 8'h10);
      bus_read(3'd1, d); chk("R7 changed sel ignored", d, 8'h20);
      chk("R7 sel_err set", sel_err, 1);
      bus_write(3'd1, 8'h20, 8'hFF);
      bus_read(3'd1, d); chk("R7 same-value write", d, 8'h20);
      bus_write(3'd0, 8'h00, 8'hFF);
      bus_read(3'd1, d); chk("R6 disable clears selectors", d, 8'h00);
      @(negedge clk);
      bus_read(3'd6, d); chk("R2 counter zero when disabled", d, 0);
   endtask

   task automatic t_free_run;
      logic [7:0] d;
      bus_write(3'd1, 8'h10, 8'hFF);
      bus_write(3'd4, 8'h40, 8'hFF);
      bus_write(3'd5, 8'h00, 8'hFF);
      bus_write(3'd0, 8'h80, 8'hFF);
      t_en = cyc;
      wait_cnt(16'd5);
      peek(3'd6, d); chk("R2 count 5", d, 5);
      @(negedge clk);
      peek(3'd6, d); chk("R2 count 6", d, 6);
      wait_cnt(16'h40);
      chk("R9 no match yet", match[1], 0);
      @(negedge clk);
      chk("R9 match pulse", match[1], 1);
      chk("R10 capture channel never matches", match[0], 0);
      @(negedge clk);
      chk("R9 match one cycle", match[1], 0);
      wait_cnt(16'h50);
      trig[0] = 1'b1;
      repeat (3) @(negedge clk);
      trig[0] = 1'b0;
      bus_read(3'd2, d); chk("R8 capture on rising edge only", d, 8'h50);
      wait_cnt(16'h60);
      trig[1] = 1'b1;
      @(negedge clk); trig[1] = 1'b0;
      bus_read(3'd4, d); chk("R10 compare channel ignores trigger", d, 8'h40);
   endtask

   task automatic t_wrap_overlap;
      logic [7:0] d;
      wait_cnt(16'hFFFE);
      bus_write(3'd1, 8'h00, 8'h01);
      bus_read(3'd1, d); chk("R5 overflow beats clear", d, 8'h11);
      chk("R3 irq pulse", irq, 1);
      peek(3'd6, d); chk("R2 wrapped to zero", d, 0);
      bus_read(3'd1, d); chk("R5 read does not clear", d, 8'h11);
      chk("R3 irq single cycle", irq, 0);
      bus_write(3'd1, 8'h01, 8'h01);
      bus_read(3'd1, d); chk("R5 write 1 no effect", d, 8'h11);
      bus_write(3'd1, 8'h00, 8'h01);
      bus_read(3'd1, d); chk("R5 write 0 clears", d, 8'h10);
   endtask

   task automatic t_plain_mode;
      logic [7:0] d;
      bus_write(3'd0, 8'h82, 8'hFF);
      irq_seen = 0;
      bus_write(3'd2, 8'h00, 8'hFF);
      bus_write(3'd3, 8'h10, 8'hFF);
      wait_cnt(16'h200);
      trig[0] = 1'b1;
      @(negedge clk); trig[0] = 1'b0;
      bus_read(3'd3, d); chk("R10 plain mode ignores trigger", d, 8'h10);
      wait_cnt(16'h1000);
      chk("R10 plain compare not yet", match[0], 0);
      @(negedge clk);
      chk("R10 plain mode compares", match[0], 1);
      wait_cnt(16'hFFFF);
      @(negedge clk);
      chk("R4 no irq in plain mode", irq, 0);
      bus_read(3'd1, d); chk("R4 no flag in plain mode", d, 8'h10);
      bus_write(3'd0, 8'h80, 8'hFF);
      chk("R4 irq never seen", irq_seen, 0);
   endtask

   task automatic t_disable_flag;
      logic [7:0] d;
      wait_cnt(16'hFFFF);
      @(negedge clk);
      chk("R3 irq after wrap", irq, 1);
      bus_read(3'd1, d); chk("R3 flag set", d, 8'h11);
      bus_write(3'd0, 8'h00, 8'h80);
      bus_read(3'd1, d); chk("R6 disable clears flag", d, 8'h00);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_option_fields();
      t_pulse_mode();
      t_free_run();
      t_wrap_overlap();
      t_plain_mode();
      t_disable_flag();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (199500) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule